// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This peripheral holds a small bank of identical 32-bit interval counters behind a synchronous word-addressed register port. Each channel has a control/status word, a reload value and a live count. Software writes a reload value and then writes the control word with the run bit set. That write copies the reload value into the counter, and the counter steps once per clock, up or down. When the channel reaches its terminal value it raises an expiry flag. It then either reloads and keeps going, or halts.

Every channel's flag is gated by its own interrupt-enable bit, and the gated flags are ORed onto one level-sensitive interrupt line. Software acknowledges an expiry by writing a one to the flag position of the control word. Several control bits (mode select, output-generate, capture, load, PWM and all-channel enable) are storage only: they are written, held and read back, and they act on nothing.

Read data is combinational from the word address, so no read strobe is needed. The asynchronous reset input is synchronised inside the block before it is released.

Top module: `tmr_bank`

## Requirements
- R1: The word address picks the channel with bits [3:2] and the register with bits [1:0]: 0 is control/status, 1 is reload value, 2 is live count and 3 is reserved. Writes to one channel leave the other channels unchanged.
- R2: Control bits 0-7, 9 and 10 are stored as written and read back. Bit 1 set means count down, bit 4 is auto-reload, bit 6 is interrupt enable and bit 7 is run. Bit 8 reads back as the expiry flag, and bits 31:11 always read zero.
- R3: The reload word stores and returns all 32 bits.
- R4: A control write with bit 7 set puts the reload value into the count on that same edge. From the next edge on, the count moves by one per clock: down when bit 1 is 1, up when it is 0.
- R5: A running down-counting channel expires on an edge where its count is zero.
- R6: A running up-counting channel expires on an edge where its count is all-ones.
- R7: On expiry the flag (bit 8) is set. With bit 4 set, the count reloads and the channel keeps running. With bit 4 clear, the count holds its terminal value and bit 7 clears itself.
- R8: A control write with bit 8 set clears the flag, and one with bit 8 clear leaves it unchanged. An expiry on the same edge as a clear wins, so the flag stays set.
- R9: The interrupt output is high exactly when some channel has both its flag and bit 6 set.
- R10: The reserved word and every word of a channel at or above NUM_CH read zero, and writes to them change nothing.
- R11: The live count word cannot be written from the bus.
- R12: After reset every readable word is zero and the interrupt is low.
- R13: A control write with bit 7 clear stops the channel, and the count then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address: channel in [3:2], register in [1:0] |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Shared level interrupt |

## Verification
Read data depends on the current address with no register in between, so a word is due in the same cycle its address is presented. A write or a count step shows up only after the one clock edge that captures it. The interrupt follows the flag registers through gates alone, so it changes on the edge that sets or clears a flag. The bench drives inputs just after each rising edge and updates its reference model on that edge. It compares the read word and the interrupt at the falling edge, which puts every comparison one edge after the cause. The reset release adds two edges of synchroniser delay, and the bench lets them pass before any traffic starts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 11;
  localparam int CH_AW  = 2;
  localparam int REG_AW = 2;
  localparam int ADDR_W = CH_AW + REG_AW;

  // control bit positions
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAP  = 3;
  localparam int B_ARL  = 4;
  localparam int B_LDB  = 5;
  localparam int B_IEN  = 6;
  localparam int B_RUN  = 7;
  localparam int B_FLAG = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  // stored control bits: everything except the flag slot
  localparam logic [CTRL_W-1:0] CTRL_KEEP = ~(CTRL_W'(1) << B_FLAG);

  typedef enum logic [REG_AW-1:0] {
    RG_CTRL = 2'd0,
    RG_LOAD = 2'd1,
    RG_CNT  = 2'd2,
    RG_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              load_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] load_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic              irq_req
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              at_term;
  logic              expire;
  logic              flag_clr;
  logic              regs_en;

  assign at_term  = ctrl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
  assign expire   = ctrl_q[B_RUN] & at_term;
  assign flag_clr = ctrl_we & wdata[B_FLAG];
  assign regs_en  = ctrl_q[B_RUN] | ctrl_we | load_we;

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    cnt_d  = cnt_q;
    if (ctrl_q[B_RUN]) begin
      if (at_term) begin
        if (ctrl_q[B_ARL]) cnt_d = load_q;
        else               ctrl_d[B_RUN] = 1'b0;
      end else if (ctrl_q[B_DOWN]) begin
        cnt_d = cnt_q - DATA_W'(1);
      end else begin
        cnt_d = cnt_q + DATA_W'(1);
      end
    end
    if (load_we) load_d = wdata;
    if (ctrl_we) begin
      ctrl_d = wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (wdata[B_RUN]) cnt_d = load_q;
    end
    flag_d = expire | (flag_q & ~flag_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (regs_en) begin
        ctrl_q <= ctrl_d;
        load_q <= load_d;
        cnt_q  <= cnt_d;
      end
      flag_q <= flag_d;
    end
  end

  assign ctrl_rd = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q | (CTRL_W'(flag_q) << B_FLAG)};
  assign load_rd = load_q;
  assign cnt_rd  = cnt_q;
  assign irq_req = flag_q & ctrl_q[B_IEN];

  // R4: a run write preloads the count
  a_r4_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[B_RUN]) |=> (cnt_q == $past(load_q)));

  // R5, R6: reaching the terminal value while running raises the flag
  a_r5_flag_on_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_RUN] && at_term) |=> flag_q);

  // R7: a one-shot channel halts after expiry
  a_r7_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_RUN] && at_term && !ctrl_q[B_ARL] && !ctrl_we) |=> !ctrl_q[B_RUN]);

  // R8: only a one in the flag slot clears the flag
  a_r8_zero_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctrl_we && wdata[B_FLAG])) |=> flag_q);

  // R13: a stopped channel holds its count
  a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_RUN] && !ctrl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_readmux.sv
module tmr_readmux
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CH_AW-1:0]              ch_sel,
  input  logic [REG_AW-1:0]             reg_sel,
  input  logic                          in_range,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] load_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cnt_rd,
  input  logic [NUM_CH-1:0]             irq_req,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          irq
);
  logic [DATA_W-1:0] ch_word;

  always_comb begin
    ch_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_AW'(i)) begin
        unique case (reg_sel)
          RG_CTRL: ch_word = ctrl_rd[i];
          RG_LOAD: ch_word = load_rd[i];
          RG_CNT:  ch_word = cnt_rd[i];
          default: ch_word = '0;
        endcase
      end
    end
  end

  assign rd_data = in_range ? ch_word : '0;
  assign irq     = |irq_req;

  // R10: reserved and absent words read zero
  a_r10_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_range || reg_sel == RG_RSVD) |-> (rd_data == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq
);
  logic                          rst_n_s;
  logic [CH_AW-1:0]              ch_sel;
  logic [REG_AW-1:0]             reg_sel;
  logic                          in_range;
  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] load_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_rd;
  logic [NUM_CH-1:0]             irq_req;

  assign ch_sel   = addr[ADDR_W-1:REG_AW];
  assign reg_sel  = addr[REG_AW-1:0];
  assign in_range = {1'b0, ch_sel} < (CH_AW+1)'(NUM_CH);

  tmr_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (ch_sel == CH_AW'(g));
    tmr_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .ctrl_we (hit && reg_sel == RG_CTRL),
      .load_we (hit && reg_sel == RG_LOAD),
      .wdata   (wr_data),
      .ctrl_rd (ctrl_rd[g]),
      .load_rd (load_rd[g]),
      .cnt_rd  (cnt_rd[g]),
      .irq_req (irq_req[g])
    );
  end

  tmr_readmux #(.NUM_CH(NUM_CH)) u_rmux (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ch_sel   (ch_sel),
    .reg_sel  (reg_sel),
    .in_range (in_range),
    .ctrl_rd  (ctrl_rd),
    .load_rd  (load_rd),
    .cnt_rd   (cnt_rd),
    .irq_req  (irq_req),
    .rd_data  (rd_data),
    .irq      (irq)
  );
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;

  int checks;
  int fails;
  bit model_on;
  bit chk_on;
  bit done;

  logic [31:0] m_ctrl [4];
  logic [31:0] m_load [4];
  logic [31:0] m_cnt  [4];
  bit          m_flag [4];

  tmr_bank #(.NUM_CH(NCH)) u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    int ch = int'(a[3:2]);
    if (ch >= NCH) return 32'h0;
    case (a[1:0])
      2'd0: return m_ctrl[ch] | (32'(m_flag[ch]) << 8);
      2'd1: return m_load[ch];
      2'd2: return m_cnt[ch];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int c = 0; c < NCH; c++) r |= m_flag[c] & m_ctrl[c][6];
    return r;
  endfunction

  // behavioural reference, one step per rising edge
  always @(posedge clk) begin
    if (model_on) begin
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] nctrl, ncnt, old_load;
        bit term, fired, clr, sel;
        old_load = m_load[c];
        nctrl = m_ctrl[c];
        ncnt  = m_cnt[c];
        term  = m_ctrl[c][1] ? (m_cnt[c] == 32'h0) : (m_cnt[c] == 32'hFFFF_FFFF);
        fired = m_ctrl[c][7] && term;
        clr   = 0;
        if (m_ctrl[c][7]) begin
          if (term) begin
            if (m_ctrl[c][4]) ncnt = old_load;
            else nctrl[7] = 1'b0;
          end else ncnt = m_ctrl[c][1] ? m_cnt[c] - 1 : m_cnt[c] + 1;
        end
        sel = wr_en && (int'(addr[3:2]) == c);
        if (sel && addr[1:0] == 2'd1) m_load[c] = wr_data;
        if (sel && addr[1:0] == 2'd0) begin
          nctrl = wr_data & 32'h0000_06FF;
          if (wr_data[7]) ncnt = old_load;
          clr = wr_data[8];
        end
        m_ctrl[c] = nctrl;
        m_cnt[c]  = ncnt;
        m_flag[c] = fired || (m_flag[c] && !clr);
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      string tag;
      if (int'(addr[3:2]) >= NCH || addr[1:0] == 2'd3) tag = "R10";
      else if (addr[1:0] == 2'd0) tag = "R2";
      else if (addr[1:0] == 2'd1) tag = "R3";
      else tag = "R4";
      check(tag, rd_data, exp_rd(addr));
      check("R9", 32'(irq), 32'(exp_irq()));
    end
  end

  logic [3:0] scan;

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      wr_en = 1'b0; addr = scan; scan = scan + 4'd1;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    check(tag, rd_data, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    checks = 0; fails = 0; model_on = 0; chk_on = 0; done = 0; scan = '0;
    for (int c = 0; c < 4; c++) begin
      m_ctrl[c] = '0; m_load[c] = '0; m_cnt[c] = '0; m_flag[c] = 0;
    end
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    // R12: reset state
    for (int a = 0; a < 16; a++) begin
      #1 addr = 4'(a);
      @(negedge clk);
      check("R12", rd_data, 32'h0);
      check("R12", 32'(irq), 32'h0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 model_on = 1; chk_on = 1;
    idle(16);

    // R3 and R1: reload words per channel
    wr(4'd1, 32'h1234_5678);
    rd_chk(4'd1, 32'h1234_5678, "R3");
    wr(4'd9, 32'hA5A5_0002);
    rd_chk(4'd9, 32'hA5A5_0002, "R1");
    rd_chk(4'd1, 32'h1234_5678, "R1");
    rd_chk(4'd5, 32'h0, "R1");

    // R2: stored bits, upper bits masked
    wr(4'd4, 32'hFFFF_FE7F);
    rd_chk(4'd4, 32'h0000_067F, "R2");
    wr(4'd4, 32'h0);

    // R5, R7: down one-shot with interrupt enabled
    wr(4'd1, 32'd5);
    wr(4'd0, 32'h0000_00C2);
    idle(12);
    rd_chk(4'd0, 32'h0000_0142, "R7");
    rd_chk(4'd2, 32'h0, "R5");
    check("R9", 32'(irq), 32'h1);

    // R8: zero in the flag slot keeps it, one clears it
    wr(4'd0, 32'h0000_0042);
    rd_chk(4'd0, 32'h0000_0142, "R8");
    wr(4'd0, 32'h0000_0142);
    rd_chk(4'd0, 32'h0000_0042, "R8");
    check("R9", 32'(irq), 32'h0);

    // R11: count word is read-only
    wr(4'd10, 32'h0000_DEAD);
    rd_chk(4'd10, 32'h0, "R11");

    // R10: reserved and absent words
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd14, 32'hFFFF_FFFF);
    wr(4'd12, 32'hFFFF_FFFF);
    rd_chk(4'd3, 32'h0, "R10");
    rd_chk(4'd14, 32'h0, "R10");
    rd_chk(4'd12, 32'h0, "R10");
    rd_chk(4'd0, 32'h0000_0042, "R10");

    // R6, R7: up counting with auto-reload
    wr(4'd5, 32'hFFFF_FFFA);
    wr(4'd4, 32'h0000_00D0);
    idle(20);
    rd_chk(4'd4, 32'h0000_01D0, "R6");
    // R8: clear issued on the expiry edge loses
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (m_cnt[1] == 32'hFFFF_FFFF) begin
        wr_en = 1'b1; addr = 4'd4; wr_data = 32'h0000_01D0;
        break;
      end
    end
    @(posedge clk); #1 wr_en = 1'b0;
    rd_chk(4'd4, 32'h0000_01D0, "R8");
    wr(4'd4, 32'h0);

    // R13: stop mid-count, count holds
    wr(4'd9, 32'd1000);
    wr(4'd8, 32'h0000_0082);
    idle(10);
    wr(4'd8, 32'h0000_0002);
    rd_chk(4'd10, m_cnt[2], "R13");
    held = rd_data;
    idle(5);
    rd_chk(4'd10, held, "R13");
    check("R13", 32'(held != 32'd1000 && held != 32'd0), 32'h1);

    // R5, R7, R8: down from zero with auto-reload expires every edge
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h0000_00D2);
    idle(4);
    wr(4'd0, 32'h0000_01D2);
    rd_chk(4'd0, 32'h0000_01D2, "R8");
    idle(20);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule